// File: doc/BRIEF.md
# Quadrature FM Discriminator with Bit-Serial Divider

This block turns a stream of complex baseband samples into one signed value per sample that is proportional to the instantaneous frequency. Each accepted sample is paired with the sample accepted just before it. The cross product of the two samples gives a phase-rotation numerator. The squared magnitude of the current sample gives a normalizing denominator. The ratio is then formed by a restoring divider that settles one quotient bit per clock.

Both stream interfaces use valid/ready. An input beat transfers on a rising edge where `in_valid` and `in_ready` are both high. An output beat transfers on a rising edge where `out_valid` and `out_ready` are both high.

Back-pressure works as follows. The block takes one sample at a time. Once a sample transfers, `in_ready` stays low until the matching result has been taken downstream, so upstream must hold its beat while `in_ready` is low. While `out_ready` is low, the offered result is held unchanged for as long as needed. Typical use is between two FIFOs in a receive chain, where the long division time is absorbed by the buffering on either side.

Top module: `fmd_discriminator`

## Requirements
- R1: For an accepted sample (I, Q), with previous accepted sample (Ip, Qp), all signed two's complement of DATA_W bits, the result is computed as follows. Let N = I·Qp − Q·Ip and D = I² + Q². The result is sign(N)·floor(|N|·2^FRAC_BITS / D), which is truncation toward zero. It is presented on `out_data` as a signed value of 2·DATA_W+FRAC_BITS+2 bits.
- R2: A beat offered on `in_valid` while `in_ready` is low is not taken. It changes neither the stored previous sample nor any later result.
- R3: When N is negative, the result is the negation of the quotient of the magnitudes, so mirrored rotations give results of equal magnitude and opposite sign.
- R4: The first sample after reset is paired with a previous sample of zero, so its result is 0.
- R5: When D is zero, no division is started. The result 0 is offered on `out_valid` in the cycle right after the accepting edge.
- R6: When D is non-zero, `out_valid` rises exactly 2·DATA_W+FRAC_BITS+2 rising edges after the accepting edge. It stays low until then.
- R7: `in_ready` is high only when no sample is in flight. It falls after an accepting edge and rises again after the edge on which the result is taken.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: During and right after reset, `in_ready` is high, `out_valid` is low, and the stored previous sample is zero.
- R10: Full-scale inputs, including −2^(DATA_W−1) on both components, give exact results with no wraparound in the numerator, the denominator or the quotient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_i | input | DATA_W | In-phase component, signed |
| in_q | input | DATA_W | Quadrature component, signed |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 2·DATA_W+FRAC_BITS+2 | Signed frequency estimate with FRAC_BITS fraction bits |

## Verification
The bound assertions check the following on every cycle:
- the handshake rules: `in_ready` falls after an accept, the two valid/ready sides never both stand open, and `in_ready` returns once the result is taken;
- the held result under a stall;
- the one-cycle zero result for a zero denominator;
- the absence of an early result when a division starts.

The arithmetic itself can only be shown by the bench's scenarios. Its model predicts every value and the exact edge of every handshake. These scenarios cover several things:
- the first-sample pairing with zero;
- mirrored rotations that flip the sign;
- full-scale corner samples;
- beats offered during a division that must be ignored;
- random streams with and without a stalling consumer.

// File: rtl/fmd_pkg.sv
package fmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV,
    ST_OUT
  } fmd_state_e;

  // width of the unsigned dividend (= quotient bits = divider iterations)
  function automatic int fmd_quot_bits(input int data_w, input int frac_w);
    return 2 * data_w + 1 + frac_w;
  endfunction

endpackage

// File: rtl/fmd_xprod.sv
module fmd_xprod #(
  parameter int DATA_W = 16,
  parameter int NUM_W  = 2 * DATA_W + 1,
  parameter int DEN_W  = 2 * DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic signed [DATA_W-1:0] cur_i,
  input  logic signed [DATA_W-1:0] cur_q,
  output logic signed [NUM_W-1:0]  num,
  output logic        [DEN_W-1:0]  den
);

  logic signed [DATA_W-1:0] prev_i;
  logic signed [DATA_W-1:0] prev_q;

  logic signed [NUM_W-1:0] rot_a;
  logic signed [NUM_W-1:0] rot_b;
  logic signed [DEN_W-1:0] pow_i;
  logic signed [DEN_W-1:0] pow_q;

  // history of the last accepted sample
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_i <= '0;
      prev_q <= '0;
    end else if (take) begin
      prev_i <= cur_i;
      prev_q <= cur_q;
    end
  end

  // operands widened before multiplying so no product can wrap
  always_comb begin
    rot_a = NUM_W'(cur_i) * NUM_W'(prev_q);
    rot_b = NUM_W'(cur_q) * NUM_W'(prev_i);
    num   = rot_a - rot_b;
    pow_i = DEN_W'(cur_i) * DEN_W'(cur_i);
    pow_q = DEN_W'(cur_q) * DEN_W'(cur_q);
    den   = $unsigned(pow_i) + $unsigned(pow_q);
  end

endmodule

// File: rtl/fmd_rdiv.sv
module fmd_rdiv #(
  parameter int DVD_W = 41,
  parameter int DSR_W = 32,
  localparam int CNT_W = $clog2(DVD_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DSR_W-1:0] divisor,
  output logic             done,
  output logic [DVD_W-1:0] quotient
);

  logic             busy;
  logic [CNT_W-1:0] step;
  logic [DVD_W-1:0] dvd_sr;
  logic [DSR_W-1:0] dsr;
  logic [DSR_W-1:0] rem;

  logic [DSR_W:0]   trial;
  logic [DSR_W-1:0] trial_diff;
  logic             fits;
  logic             last;

  always_comb begin
    trial      = {rem, dvd_sr[DVD_W-1]};
    fits       = trial >= {1'b0, dsr};
    trial_diff = trial[DSR_W-1:0] - dsr;
    last       = step == CNT_W'(DVD_W - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      step     <= '0;
      dvd_sr   <= '0;
      dsr      <= '0;
      rem      <= '0;
      quotient <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      step     <= '0;
      dvd_sr   <= dividend;
      dsr      <= divisor;
      rem      <= '0;
      quotient <= '0;
    end else if (busy) begin
      // one restoring step: keep the difference only if it is non-negative
      rem      <= fits ? trial_diff : trial[DSR_W-1:0];
      quotient <= {quotient[DVD_W-2:0], fits};
      dvd_sr   <= dvd_sr << 1;
      step     <= step + 1'b1;
      if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

endmodule

// File: rtl/fmd_discriminator.sv
module fmd_discriminator #(
  parameter int DATA_W    = 16,
  parameter int FRAC_BITS = 8,
  localparam int OUT_W    = 2 * DATA_W + FRAC_BITS + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [DATA_W-1:0]       in_i,
  input  logic [DATA_W-1:0]       in_q,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [OUT_W-1:0]        out_data
);
  import fmd_pkg::*;

  localparam int NUM_W = 2 * DATA_W + 1;
  localparam int DEN_W = 2 * DATA_W;
  localparam int DVD_W = fmd_quot_bits(DATA_W, FRAC_BITS);

  fmd_state_e state;

  logic                    accept;
  logic signed [NUM_W-1:0] num_w;
  logic [DEN_W-1:0]        den_w;
  logic [NUM_W-1:0]        num_abs;
  logic [DVD_W-1:0]        dividend;
  logic                    div_start;
  logic                    div_done;
  logic [DVD_W-1:0]        div_q;
  logic                    neg_q;
  logic [OUT_W-1:0]        result;
  logic [OUT_W-1:0]        signed_q;

  assign in_ready  = state == ST_IDLE;
  assign accept    = in_valid && in_ready;
  assign out_valid = state == ST_OUT;
  assign out_data  = result;

  fmd_xprod #(
    .DATA_W(DATA_W),
    .NUM_W (NUM_W),
    .DEN_W (DEN_W)
  ) u_xprod (
    .clk  (clk),
    .rst_n(rst_n),
    .take (accept),
    .cur_i($signed(in_i)),
    .cur_q($signed(in_q)),
    .num  (num_w),
    .den  (den_w)
  );

  // sign removed before the unsigned division, restored afterwards
  always_comb begin
    num_abs   = $unsigned(num_w[NUM_W-1] ? -num_w : num_w);
    dividend  = DVD_W'(num_abs) << FRAC_BITS;
    div_start = accept && (den_w != '0);
    signed_q  = neg_q ? -{1'b0, div_q} : {1'b0, div_q};
  end

  fmd_rdiv #(
    .DVD_W(DVD_W),
    .DSR_W(DEN_W)
  ) u_rdiv (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (div_start),
    .dividend(dividend),
    .divisor (den_w),
    .done    (div_done),
    .quotient(div_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      neg_q  <= 1'b0;
      result <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            neg_q <= num_w[NUM_W-1];
            if (den_w == '0) begin
              result <= '0;
              state  <= ST_OUT;
            end else begin
              state <= ST_DIV;
            end
          end
        end
        ST_DIV: begin
          if (div_done) begin
            result <= signed_q;
            state  <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fmd_discriminator_chk.sv
module fmd_discriminator_chk #(
  parameter int OUT_W = 42,
  parameter int DEN_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic [DEN_W-1:0] den
);

  // R7
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R7
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R7
  release_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5
  zero_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && den == '0) |=> (out_valid && out_data == '0));

  // R6
  no_early_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && den != '0) |=> !out_valid);

endmodule

bind fmd_discriminator fmd_discriminator_chk #(
  .OUT_W(OUT_W),
  .DEN_W(2 * DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .den      (den_w)
);

// File: tb/fmd_discriminator_bench.sv
`timescale 1ns/1ps
module fmd_discriminator_bench;

  localparam int DATA_W    = 16;
  localparam int FRAC_BITS = 8;
  localparam int QW        = 2 * DATA_W + 1 + FRAC_BITS;
  localparam int OUT_W     = QW + 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [DATA_W-1:0] in_i;
  logic [DATA_W-1:0] in_q;
  logic              out_valid;
  logic              out_ready;
  logic [OUT_W-1:0]  out_data;

  fmd_discriminator #(
    .DATA_W   (DATA_W),
    .FRAC_BITS(FRAC_BITS)
  ) u_fmd_discriminator (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_i     (in_i),
    .in_q     (in_q),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int     mode;      // 0 waiting for input, 1 dividing, 2 offering result
  int     cd;
  longint prev_i, prev_q, exp_val;
  string  exp_tag;
  bit     acc_flag, first, stalled;
  bit     stall_en, r2_mode, fs_mode, running;
  int unsigned seed = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    acc_flag = 1'b0;
    if (!rst_n) begin
      mode = 0; cd = 0; prev_i = 0; prev_q = 0; first = 1'b1; stalled = 1'b0;
    end else begin
      stalled = (mode == 2) && !out_ready;
      case (mode)
        0: if (in_valid) begin
          longint ci, cq, n, d, m;
          ci = longint'($signed(in_i));
          cq = longint'($signed(in_q));
          n  = ci * prev_q - cq * prev_i;
          d  = ci * ci + cq * cq;
          if (d == 0) begin
            exp_val = 0; mode = 2; exp_tag = "R5";
          end else begin
            m = ((n < 0) ? -n : n) * (64'sd1 <<< FRAC_BITS);
            exp_val = (n < 0) ? -(m / d) : (m / d);
            mode = 1; cd = QW + 1;
            if (first)         exp_tag = "R4";
            else if (fs_mode)  exp_tag = "R10";
            else if (r2_mode)  exp_tag = "R2";
            else if (stall_en) exp_tag = "R8";
            else if (n < 0)    exp_tag = "R3";
            else               exp_tag = "R1";
          end
          prev_i = ci; prev_q = cq; first = 1'b0; acc_flag = 1'b1;
        end
        1: begin
          cd--;
          if (cd == 0) mode = 2;
        end
        default: if (out_ready) mode = 0;
      endcase
    end
  end

  // compared on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && running) begin
      check(in_ready == (mode == 0), "R7", longint'(in_ready), longint'(mode == 0));
      check(out_valid == (mode == 2), "R6", longint'(out_valid), longint'(mode == 2));
      if (mode == 2 && out_valid)
        check(longint'($signed(out_data)) == exp_val, stalled ? "R8" : exp_tag,
              longint'($signed(out_data)), exp_val);
    end
  end

  int cyc = 0;
  initial begin
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = stall_en ? (cyc % 4 == 3) : 1'b1;
    end
  end

  function automatic int rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[31:16]));
  endfunction

  task automatic send(input int si, input int sq, input int junk);
    in_valid = 1'b1;
    in_i = DATA_W'(si);
    in_q = DATA_W'(sq);
    do @(negedge clk); while (!acc_flag);
    if (junk > 0) begin
      for (int k = 0; k < junk; k++) begin
        in_i = DATA_W'(rnd16());
        in_q = DATA_W'(rnd16());
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0;
    stall_en = 1'b0; r2_mode = 1'b0; fs_mode = 1'b0; running = 1'b0;
    repeat (4) @(negedge clk);
    // R9: reset state
    check(in_ready == 1'b1, "R9", longint'(in_ready), 1);
    check(out_valid == 1'b0, "R9", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R9", longint'(in_ready), 1);
    check(out_valid == 1'b0, "R9", longint'(out_valid), 0);
    running = 1'b1;

    // R4: pairing with zero history
    send(1000, 2000, 0);
    // R1/R3: rotation one way, then mirrored the other way
    send(3000, 0, 0);
    send(2121, 2121, 0);
    send(0, 3000, 0);
    send(-2121, 2121, 0);
    send(0, 3000, 0);
    send(2121, 2121, 0);
    send(3000, 0, 0);
    // R5: zero denominators
    send(0, 0, 0);
    send(0, 0, 0);
    send(500, -700, 0);
    send(0, 0, 0);
    // R10: full-scale corners
    fs_mode = 1'b1;
    send(-32768, -32768, 0);
    send(-32768, 32767, 0);
    send(32767, -32768, 0);
    send(32767, 32767, 0);
    send(-32768, 0, 0);
    send(1, 1, 0);
    fs_mode = 1'b0;
    // R8: stalling consumer
    stall_en = 1'b1;
    for (int k = 0; k < 10; k++) send(rnd16(), rnd16(), 0);
    stall_en = 1'b0;
    // R2: beats offered during a division are ignored
    r2_mode = 1'b1;
    for (int k = 0; k < 6; k++) send(rnd16(), rnd16(), 10);
    r2_mode = 1'b0;
    // R1: random stream
    for (int k = 0; k < 60; k++) send(rnd16(), rnd16(), 0);
    repeat (QW + 10) @(negedge clk);
    running = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R6: watchdog expired, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule